// File: doc/BRIEF.md
# Segment-Granular Code Page Translator

This block sits between a processor's fetch or branch logic and a small execution buffer made of SRAM pages. Code lives in a flat image in slow page-oriented storage. The image is cut into segments, and each segment spans a whole number of image pages. A request carries an absolute image address. The block looks up the page holding that address. If the page is resident, the block answers with the matching physical buffer address. If it is not resident, the block first frees buffer pages for the whole segment and asks an external loader to copy the segment in. When the loader reports completion, the block updates its tables and returns the translated address.

Buffer space is handed out by a next-free-page pointer that advances segment by segment. The pointer goes back to page 0 whenever the segment would run past the end of the buffer. Every buffer page that a new segment overwrites is looked up in a reverse table, which records which image page occupied it, and that image page is marked non-resident. The same reverse table serves a combinational back-translation port. This port turns a buffer address, such as a saved return link, into the image address it came from.

The segment map and the segment extents are written through a small configuration port while the block is held idle.

Top module: `seg_pager`

## Requirements
- R1: After reset no image page is resident, no buffer page has an owner, the allocation pointer is 0, the load request is low and ready_o is high while cfg_en_i is low.
- R2: The image page of a request is (address − IMG_BASE) >> PAGE_SHIFT, and the low PAGE_SHIFT bits are the in-page offset. On a hit, rsp_valid_o pulses one cycle after acceptance, with rsp_hit_o=1 and rsp_addr_o = BUF_BASE + (buffer page << PAGE_SHIFT) + offset.
- R3: On a miss, the segment comes from the page-to-segment map. Two cycles after acceptance, ld_req_o rises carrying the segment's first image page, its page count and the destination buffer page. ld_req_o stays high, with no response, until ld_done_i is seen.
- R4: If the pointer plus the segment length exceeds BUF_PAGES, the destination is buffer page 0. Otherwise the destination is the pointer, so a segment that exactly reaches the buffer end does not wrap.
- R5: Before the load, every image page whose owner slot lies in destination..destination+length−1 becomes non-resident. Pages of the same segment held in other buffer pages stay resident.
- R6: One cycle after ld_done_i, rsp_valid_o pulses with rsp_hit_o=0 and rsp_addr_o = BUF_BASE + ((destination + page − first page) << PAGE_SHIFT) + offset. From then on, every page of the segment hits at its new location.
- R7: After a load, the pointer equals destination plus segment length.
- R8: rev_addr_o = IMG_BASE + (owner image page << PAGE_SHIFT) + offset, where the buffer page is (rev_addr_i − BUF_BASE) >> PAGE_SHIFT.
- R9: rev_err_o is 1 when the addressed buffer page has no owner.
- R10: While cfg_en_i is high, ready_o is low and requests are ignored. Configuration writes use cfg_sel_i codes 0 (image page cfg_idx_i belongs to segment cfg_data_i), 1 (first page of segment cfg_idx_i) and 2 (page count of segment cfg_idx_i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_en_i | input | 1 | Hold idle and enable table writes |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_sel_i | input | 2 | Table select code |
| cfg_idx_i | input | IW | Entry index |
| cfg_data_i | input | 16 | Entry value (low bits used) |
| req_valid_i | input | 1 | Translation request |
| req_addr_i | input | ADDR_W | Absolute image address |
| ready_o | output | 1 | Block can accept a request |
| rsp_valid_o | output | 1 | Translated address valid (one cycle) |
| rsp_hit_o | output | 1 | Response came from a resident page |
| rsp_addr_o | output | ADDR_W | Buffer address |
| ld_req_o | output | 1 | Segment load request |
| ld_start_o | output | IW | First image page of segment |
| ld_len_o | output | LW | Segment page count |
| ld_dst_o | output | BW | First destination buffer page |
| ld_done_i | input | 1 | Load completion pulse |
| rev_addr_i | input | ADDR_W | Buffer address to back-translate |
| rev_addr_o | output | ADDR_W | Matching image address |
| rev_err_o | output | 1 | Buffer page has no owner |

## Verification
The bench builds the block with 256-byte pages, four buffer pages, sixteen image pages and eight segments, and it uses distinct, nonzero image and buffer bases. With only four buffer pages, a three-page segment followed by single-page and two-page segments reaches every pointer case in a few requests. These cases are an exact fit at the buffer end, a wrap to zero, and a partial overwrite that leaves part of an older segment resident. The nonzero bases catch any formula that drops a base term or mixes the two address spaces.

// File: rtl/seg_pager_pkg.sv
package seg_pager_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_LOAD  = 2'd2
  } pager_state_e;

  localparam logic [1:0] CFG_PG_SEG    = 2'd0;
  localparam logic [1:0] CFG_SEG_START = 2'd1;
  localparam logic [1:0] CFG_SEG_LEN   = 2'd2;
endpackage

// File: rtl/seg_pager_xlate.sv
module seg_pager_xlate #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_SHIFT = 9,
  parameter int unsigned IW         = 4,
  parameter int unsigned BW         = 2,
  parameter logic [ADDR_W-1:0] IMG_BASE = '0,
  parameter logic [ADDR_W-1:0] BUF_BASE = '0
) (
  input  logic [ADDR_W-1:0]     img_addr_i,
  output logic [IW-1:0]         img_page_o,
  output logic [PAGE_SHIFT-1:0] img_off_o,
  input  logic [BW-1:0]         out_bpage_i,
  input  logic [PAGE_SHIFT-1:0] out_off_i,
  output logic [ADDR_W-1:0]     buf_addr_o,
  input  logic [ADDR_W-1:0]     buf_addr_i,
  output logic [BW-1:0]         buf_page_o,
  input  logic [IW-1:0]         own_page_i,
  output logic [ADDR_W-1:0]     back_addr_o
);
  logic [ADDR_W-1:0] img_rel, buf_rel;
  logic [PAGE_SHIFT-1:0] buf_off;

  always_comb begin
    img_rel     = img_addr_i - IMG_BASE;
    img_page_o  = IW'(img_rel >> PAGE_SHIFT);
    img_off_o   = img_rel[PAGE_SHIFT-1:0];
    buf_addr_o  = BUF_BASE + (ADDR_W'(out_bpage_i) << PAGE_SHIFT) + ADDR_W'(out_off_i);
    buf_rel     = buf_addr_i - BUF_BASE;
    buf_page_o  = BW'(buf_rel >> PAGE_SHIFT);
    buf_off     = buf_rel[PAGE_SHIFT-1:0];
    back_addr_o = IMG_BASE + (ADDR_W'(own_page_i) << PAGE_SHIFT) + ADDR_W'(buf_off);
  end
endmodule

// File: rtl/seg_pager_alloc.sv
module seg_pager_alloc #(
  parameter int unsigned BUF_PAGES = 4,
  localparam int unsigned LW = $clog2(BUF_PAGES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] len_i,
  input  logic          advance_i,
  output logic [LW-1:0] dst_o
);
  logic [LW-1:0] ptr_q;
  logic          wrap;

  // wrap when the segment would run past the buffer end
  assign wrap  = (int'(ptr_q) + int'(len_i)) > int'(BUF_PAGES);
  assign dst_o = wrap ? '0 : ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (advance_i) ptr_q <= dst_o + len_i;
  end

  // R7
  ptr_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ptr_q) <= int'(BUF_PAGES));
endmodule

// File: rtl/seg_pager.sv
module seg_pager import seg_pager_pkg::*; #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_SHIFT = 9,
  parameter int unsigned BUF_PAGES  = 4,
  parameter int unsigned IMG_PAGES  = 16,
  parameter int unsigned SEGS       = 8,
  parameter logic [ADDR_W-1:0] IMG_BASE = 32'h0800_0000,
  parameter logic [ADDR_W-1:0] BUF_BASE = 32'h2000_0000,
  localparam int unsigned IW = $clog2(IMG_PAGES),
  localparam int unsigned SW = $clog2(SEGS),
  localparam int unsigned BW = $clog2(BUF_PAGES),
  localparam int unsigned LW = $clog2(BUF_PAGES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [IW-1:0]     cfg_idx_i,
  input  logic [15:0]       cfg_data_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              ready_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic              ld_req_o,
  output logic [IW-1:0]     ld_start_o,
  output logic [LW-1:0]     ld_len_o,
  output logic [BW-1:0]     ld_dst_o,
  input  logic              ld_done_i,
  input  logic [ADDR_W-1:0] rev_addr_i,
  output logic [ADDR_W-1:0] rev_addr_o,
  output logic              rev_err_o
);
  pager_state_e state_q;

  // tables
  logic [SW-1:0] pt_seg  [IMG_PAGES];
  logic [BW-1:0] pt_buf  [IMG_PAGES];
  logic          pt_vld  [IMG_PAGES];
  logic [IW-1:0] bpt_own [BUF_PAGES];
  logic          bpt_vld [BUF_PAGES];
  logic [IW-1:0] seg_start [SEGS];
  logic [LW-1:0] seg_len   [SEGS];

  // miss context
  logic [IW-1:0]         page_q, start_q;
  logic [PAGE_SHIFT-1:0] off_q;
  logic [LW-1:0]         len_q, dst_q;

  logic [IW-1:0]         f_page;
  logic [PAGE_SHIFT-1:0] f_off;
  logic [BW-1:0]         r_page;
  logic [BW-1:0]         out_bpage;
  logic [PAGE_SHIFT-1:0] out_off;
  logic [ADDR_W-1:0]     out_addr;
  logic [SW-1:0]         cur_seg;
  logic [LW-1:0]         alloc_len, alloc_dst;
  logic                  accept, hit, load_fin;

  assign ready_o  = (state_q == ST_IDLE) && !cfg_en_i;
  assign accept   = ready_o && req_valid_i;
  assign hit      = pt_vld[f_page];
  assign cur_seg  = pt_seg[f_page];
  assign load_fin = (state_q == ST_LOAD) && ld_done_i;

  assign alloc_len = (state_q == ST_IDLE) ? seg_len[cur_seg] : len_q;
  assign out_bpage = (state_q == ST_IDLE) ? pt_buf[f_page]
                                          : BW'(dst_q + LW'(page_q - start_q));
  assign out_off   = (state_q == ST_IDLE) ? f_off : off_q;

  seg_pager_xlate #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .IW(IW), .BW(BW),
    .IMG_BASE(IMG_BASE), .BUF_BASE(BUF_BASE)
  ) u_xlate (
    .img_addr_i (req_addr_i),
    .img_page_o (f_page),
    .img_off_o  (f_off),
    .out_bpage_i(out_bpage),
    .out_off_i  (out_off),
    .buf_addr_o (out_addr),
    .buf_addr_i (rev_addr_i),
    .buf_page_o (r_page),
    .own_page_i (bpt_own[r_page]),
    .back_addr_o(rev_addr_o)
  );

  assign rev_err_o = !bpt_vld[r_page];

  seg_pager_alloc #(.BUF_PAGES(BUF_PAGES)) u_alloc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .len_i    (alloc_len),
    .advance_i(load_fin),
    .dst_o    (alloc_dst)
  );

  assign ld_req_o   = (state_q == ST_LOAD);
  assign ld_start_o = start_q;
  assign ld_len_o   = len_q;
  assign ld_dst_o   = BW'(dst_q);

  // control and response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_addr_o  <= '0;
      page_q      <= '0;
      start_q     <= '0;
      off_q       <= '0;
      len_q       <= '0;
      dst_q       <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (hit) begin
            rsp_valid_o <= 1'b1;
            rsp_hit_o   <= 1'b1;
            rsp_addr_o  <= out_addr;
          end else begin
            page_q  <= f_page;
            off_q   <= f_off;
            start_q <= seg_start[cur_seg];
            len_q   <= seg_len[cur_seg];
            dst_q   <= alloc_dst;
            state_q <= ST_EVICT;
          end
        end
        ST_EVICT: state_q <= ST_LOAD;
        ST_LOAD: if (ld_done_i) begin
          rsp_valid_o <= 1'b1;
          rsp_hit_o   <= 1'b0;
          rsp_addr_o  <= out_addr;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // configuration tables
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < IMG_PAGES; i++) pt_seg[i] <= '0;
      for (int s = 0; s < SEGS; s++) begin
        seg_start[s] <= '0;
        seg_len[s]   <= '0;
      end
    end else if (cfg_en_i && cfg_we_i && state_q == ST_IDLE) begin
      unique case (cfg_sel_i)
        CFG_PG_SEG:    pt_seg[cfg_idx_i] <= cfg_data_i[SW-1:0];
        CFG_SEG_START: seg_start[SW'(cfg_idx_i)] <= cfg_data_i[IW-1:0];
        CFG_SEG_LEN:   seg_len[SW'(cfg_idx_i)] <= cfg_data_i[LW-1:0];
        default: ;
      endcase
    end
  end

  // residency tables
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < IMG_PAGES; i++) begin
        pt_vld[i] <= 1'b0;
        pt_buf[i] <= '0;
      end
      for (int k = 0; k < BUF_PAGES; k++) begin
        bpt_vld[k] <= 1'b0;
        bpt_own[k] <= '0;
      end
    end else if (state_q == ST_EVICT) begin
      // displace owners of the destination window via the reverse table
      for (int k = 0; k < BUF_PAGES; k++) begin
        if (k >= int'(dst_q) && k < int'(dst_q) + int'(len_q) && bpt_vld[k]) begin
          pt_vld[bpt_own[k]] <= 1'b0;
          bpt_vld[k]         <= 1'b0;
        end
      end
    end else if (load_fin) begin
      for (int i = 0; i < IMG_PAGES; i++) begin
        if (i >= int'(start_q) && i < int'(start_q) + int'(len_q)) begin
          pt_vld[i] <= 1'b1;
          pt_buf[i] <= BW'(int'(dst_q) + i - int'(start_q));
        end
      end
      for (int k = 0; k < BUF_PAGES; k++) begin
        if (k >= int'(dst_q) && k < int'(dst_q) + int'(len_q)) begin
          bpt_vld[k] <= 1'b1;
          bpt_own[k] <= IW'(int'(start_q) + k - int'(dst_q));
        end
      end
    end
  end

  // R3
  ld_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_req_o && !ld_done_i |=> ld_req_o && !rsp_valid_o);
  // R4
  ld_fit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_req_o |-> int'(ld_dst_o) + int'(ld_len_o) <= int'(BUF_PAGES));
  // R6
  miss_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_hit_o |-> $past(ld_done_i) && $past(ld_req_o));
  // R10
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_req_o |-> !ready_o);
  // R2
  hit_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_hit_o |-> $past(req_valid_i) && $past(ready_o));
endmodule

// File: tb/tb_seg_pager.sv
`timescale 1ns/1ps
module tb_seg_pager;
  localparam logic [31:0] IB = 32'h0001_0000;
  localparam logic [31:0] BB = 32'h2000_0000;

  logic clk = 0, rst_n = 0;
  logic cfg_en = 0, cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [3:0] cfg_idx = 0;
  logic [15:0] cfg_data = 0;
  logic req_valid = 0;
  logic [31:0] req_addr = 0;
  logic ready, rsp_valid, rsp_hit, ld_req, ld_done = 0, rev_err;
  logic [31:0] rsp_addr, rev_addr = BB, rev_out;
  logic [3:0] ld_start;
  logic [2:0] ld_len;
  logic [1:0] ld_dst;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  seg_pager #(.ADDR_W(32), .PAGE_SHIFT(8), .BUF_PAGES(4), .IMG_PAGES(16), .SEGS(8),
              .IMG_BASE(IB), .BUF_BASE(BB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_we_i(cfg_we),
    .cfg_sel_i(cfg_sel), .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .ready_o(ready),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_addr_o(rsp_addr),
    .ld_req_o(ld_req), .ld_start_o(ld_start), .ld_len_o(ld_len), .ld_dst_o(ld_dst),
    .ld_done_i(ld_done), .rev_addr_i(rev_addr), .rev_addr_o(rev_out), .rev_err_o(rev_err));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input int idx, input int data);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_idx = 4'(idx); cfg_data = 16'(data);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic xlate(input string tag, input logic [31:0] a, input bit exp_hit,
                       input int es, input int el, input int ed, input logic [31:0] ex);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    if (exp_hit) begin
      check({tag, " R2 hit valid"}, {31'd0, rsp_valid}, 1);
      check({tag, " R2 hit flag"}, {31'd0, rsp_hit}, 1);
      check({tag, " R2 hit addr"}, rsp_addr, ex);
    end else begin
      check({tag, " R3 no early rsp"}, {31'd0, rsp_valid}, 0);
      @(negedge clk);
      check({tag, " R3 ld_req"}, {31'd0, ld_req}, 1);
      check({tag, " R3 ld_start"}, {28'd0, ld_start}, 32'(es));
      check({tag, " R3 ld_len"}, {29'd0, ld_len}, 32'(el));
      check({tag, " R4 ld_dst"}, {30'd0, ld_dst}, 32'(ed));
      repeat (3) @(negedge clk);
      check({tag, " R3 held"}, {30'd0, ld_req, rsp_valid}, 32'b10);
      ld_done = 1;
      @(negedge clk);
      ld_done = 0;
      check({tag, " R6 miss valid"}, {31'd0, rsp_valid}, 1);
      check({tag, " R6 miss flag"}, {31'd0, rsp_hit}, 0);
      check({tag, " R6 miss addr"}, rsp_addr, ex);
      check({tag, " R6 ld_req drop"}, {31'd0, ld_req}, 0);
    end
    @(negedge clk);
    check({tag, " R2 single pulse"}, {31'd0, rsp_valid}, 0);
  endtask

  task automatic rev(input string tag, input logic [31:0] a, input bit exp_err, input logic [31:0] ex);
    @(negedge clk);
    rev_addr = a;
    #1;
    check({tag, " R9 err"}, {31'd0, rev_err}, {31'd0, exp_err});
    if (!exp_err) check({tag, " R8 back addr"}, rev_out, ex);
  endtask

  task automatic t_reset;
    check("R1 ready", {31'd0, ready}, 1);
    check("R1 ld_req", {31'd0, ld_req}, 0);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 0);
    rev("R1 reset", BB + 32'h080, 1'b1, 0);
    rev("R1 reset buf3", BB + 32'h3F0, 1'b1, 0);
  endtask

  task automatic t_config;
    @(negedge clk);
    cfg_en = 1;
    #1 check("R10 not ready in cfg", {31'd0, ready}, 0);
    for (int i = 0; i < 3; i++) cfg_wr(2'd0, i, 0);
    cfg_wr(2'd0, 3, 1);
    cfg_wr(2'd0, 4, 2);
    cfg_wr(2'd0, 5, 2);
    cfg_wr(2'd0, 6, 3);
    cfg_wr(2'd1, 0, 0); cfg_wr(2'd2, 0, 3);
    cfg_wr(2'd1, 1, 3); cfg_wr(2'd2, 1, 1);
    cfg_wr(2'd1, 2, 4); cfg_wr(2'd2, 2, 2);
    cfg_wr(2'd1, 3, 6); cfg_wr(2'd2, 3, 1);
    // request while held: ignored
    @(negedge clk);
    req_valid = 1; req_addr = IB + 32'h124;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    check("R10 ignored rsp", {31'd0, rsp_valid}, 0);
    check("R10 ignored ld", {31'd0, ld_req}, 0);
    rev("R10 nothing loaded", BB, 1'b1, 0);
    cfg_en = 0;
    #1 check("R10 ready after cfg", {31'd0, ready}, 1);
  endtask

  task automatic t_fill;
    xlate("T1", IB + 32'h124, 0, 0, 3, 0, BB + 32'h124);
    xlate("T2", IB + 32'h210, 1, 0, 0, 0, BB + 32'h210);
    xlate("T3 exact fit R4", IB + 32'h30C, 0, 3, 1, 3, BB + 32'h30C);
    rev("R8 buf3", BB + 32'h3AB, 1'b0, IB + 32'h3AB);
  endtask

  task automatic t_wrap;
    xlate("T4 wrap R4", IB + 32'h5A0, 0, 4, 2, 0, BB + 32'h1A0);
    xlate("T5 R5 survivor", IB + 32'h2FF, 1, 0, 0, 0, BB + 32'h2FF);
    xlate("T5b R6 sibling", IB + 32'h410, 1, 0, 0, 0, BB + 32'h010);
    rev("R8 buf1", BB + 32'h140, 1'b0, IB + 32'h540);
    rev("R8 buf0", BB + 32'h000, 1'b0, IB + 32'h400);
    xlate("T6 R5 evicted", IB + 32'h124, 0, 0, 3, 0, BB + 32'h124);
    xlate("T7 R7 ptr3", IB + 32'h5A0, 0, 4, 2, 0, BB + 32'h1A0);
    xlate("T8 untouched", IB + 32'h308, 1, 0, 0, 0, BB + 32'h308);
    xlate("T9 R7 ptr2", IB + 32'h600, 0, 6, 1, 2, BB + 32'h200);
    xlate("T10 R6 new hit", IB + 32'h650, 1, 0, 0, 0, BB + 32'h250);
    rev("R8 buf2", BB + 32'h2C4, 1'b0, IB + 32'h6C4);
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_config();
    t_fill();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule